// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block sends a single SD/MMC command on behalf of a host controller and keeps the card's reply. Software first loads a 32-bit argument and then writes a 16-bit command word. Writing the command word starts the command, but only if the inhibit flags allow it. The block then asks a line serializer for one frame. The serializer is modelled only as a handshake: a start pulse, then a done pulse that carries the raw frame together with timeout and CRC-error flags. When the frame returns, the block stores the reply in four 32-bit words, checks the index and the CRC if the command word asked for that, and updates sticky status bits that software clears by writing 1.

The response type is a 2-bit code. One of its values means a short reply after which the card holds DAT0 low while it is busy. For that type, completion waits until DAT0 goes high again, but the CMD line is released as soon as the reply arrives. A 136-bit reply is stored without its CRC byte, so each stored word sits 8 bits lower than the same bits in the raw frame.

Top module: `sdcmd_issue`

## Requirements
- R1: The cycle after an accepted command-word write, `ser_start` is high for exactly one cycle. During that cycle `ser_index` equals command-word bits 13:8, `ser_arg` equals the last argument written, and `ser_long` is 1 only when response type (bits 1:0) is 01.
- R2: `present_state` bit 0 (CMD inhibit) is 1 from the cycle after an accepted write until the serializer's done is taken. Bit 1 (DAT inhibit) is 1 while a command with data present (bit 5) or with busy type 11 is pending. Bits 23:20 mirror `dat_in`, and all other bits read 0.
- R3: A command-word write is ignored (no `ser_start`) while CMD inhibit is set. It is also ignored while DAT inhibit is set if the new command has bit 5 set or type 11.
- R4: Type 00 (no response) sets status bit 0 (complete) and clears CMD inhibit at the done edge. The response words are left unchanged.
- R5: Types 10 and 11 load response word 0 with frame bits 39:8 and leave words 1 to 3 unchanged. The response words never change while CMD inhibit is clear.
- R6: Type 01 loads the 128-bit response with eight zero bits followed by frame bits 127:8.
- R7: With index check enabled (bit 4) and a type of 10 or 11, a mismatch between frame bits 45:40 and the issued index sets status bit 3 and status bit 4 (error summary). Completion is still reported. With the check disabled, a mismatch has no effect.
- R8: With CRC check enabled (bit 3) and a type other than 00, `ser_crc_err` at done sets status bit 2 and bit 4. With the check disabled, the flag is ignored.
- R9: `ser_timeout` at done sets status bit 1 and bit 4, does not set complete, leaves the response unchanged, and clears both inhibit flags.
- R10: For type 11, complete is set only at the first clock edge after the reply where `dat_in[0]` is 1. DAT inhibit clears on that same edge.
- R11: DAT inhibit held by a data-present command clears on a `xfer_done` pulse.
- R12: Writing status with `sts_w1c_we` clears each bit written as 1 and leaves bits written as 0 unchanged. A bit set by an event on the same edge stays set.
- R13: After reset, the status and response registers are zero and both inhibit flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Command word write strobe (launches the command) |
| cmd_wdata | input | 16 | Command word: index 13:8, data 5, index check 4, CRC check 3, type 1:0 |
| sts_w1c_we | input | 1 | Status clear strobe |
| sts_w1c_data | input | 5 | Status bits to clear (1 clears) |
| dat_in | input | 4 | DAT3..DAT0 line levels |
| xfer_done | input | 1 | Data path finished pulse |
| ser_start | output | 1 | Serializer start pulse |
| ser_index | output | 6 | Command index for the serializer |
| ser_arg | output | 32 | Argument for the serializer |
| ser_long | output | 1 | Expect a 136-bit reply |
| ser_done | input | 1 | Serializer finished pulse |
| ser_timeout | input | 1 | No reply arrived (valid with done) |
| ser_crc_err | input | 1 | Reply CRC was bad (valid with done) |
| ser_frame | input | 136 | Raw reply frame, LSB-aligned (valid with done) |
| present_state | output | 32 | Inhibit flags and line levels |
| status | output | 5 | Complete 0, timeout 1, CRC 2, index 3, error summary 4 |
| resp_q | output | 128 | Response words, word i at bits 32i+31:32i |

## Verification
`ser_start` rises one cycle after the edge that takes the command write. Every result of a reply (response words, complete, error bits and the release of CMD inhibit) appears right after the edge that samples `ser_done`. A busy completion appears after the first edge that sees DAT0 high, and W1C clears appear after the edge of the write. The bench drives inputs on the falling edge, updates a behavioural model on the rising edge, and compares every output a quarter period after each rising edge, so each expected value is read exactly in the cycle it becomes due. Directed checks on refused writes, busy waiting and data release sample after those same edges.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int IDX_W      = 6;
    localparam int ARG_W      = 32;
    localparam int WORD_W     = 32;
    localparam int RSP_WORDS  = 4;
    localparam int CRC_W      = 8;
    localparam int STS_W      = 5;
    localparam int FR_IDX_LSB = 40;     // index field position in a short frame

    // status bit positions
    localparam int ST_CMPL = 0;
    localparam int ST_TMO  = 1;
    localparam int ST_CRC  = 2;
    localparam int ST_IDX  = 3;
    localparam int ST_ERR  = 4;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'b00,
        RSP_LONG       = 2'b01,
        RSP_SHORT      = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             with_data;
        logic             idx_chk;
        logic             crc_chk;
        rsp_kind_e        kind;
    } cmd_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_WAIT} seq_e;

    function automatic cmd_t decode_cmd(input logic [15:0] w);
        cmd_t c;
        c.idx       = w[13:8];
        c.with_data = w[5];
        c.idx_chk   = w[4];
        c.crc_chk   = w[3];
        c.kind      = rsp_kind_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic needs_dat(input cmd_t c);
        return c.with_data || (c.kind == RSP_SHORT_BUSY);
    endfunction
endpackage

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic [15:0] cmd_wdata,
    input  logic        ser_done,
    input  logic        ser_timeout,
    input  logic        dat0,
    input  logic        xfer_done,
    output logic        ser_start,
    output cmd_t        cur,
    output logic        cmd_inh,
    output logic        dat_inh,
    output logic        cap_evt,
    output logic        tmo_evt,
    output logic        busy_ok_evt
);
    seq_e st;
    cmd_t wr;
    logic accept, done_evt;
    logic busy_pend, busy_arm, data_pend;

    assign wr          = decode_cmd(cmd_wdata);
    assign cmd_inh     = (st != SQ_IDLE);
    assign dat_inh     = busy_pend | data_pend;
    assign accept      = cmd_we && !cmd_inh && !(dat_inh && needs_dat(wr));
    assign done_evt    = (st == SQ_WAIT) && ser_done;
    assign cap_evt     = done_evt && !ser_timeout;
    assign tmo_evt     = done_evt && ser_timeout;
    assign busy_ok_evt = busy_arm && dat0;
    assign ser_start   = (st == SQ_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            cur       <= '0;
            busy_pend <= 1'b0;
            busy_arm  <= 1'b0;
            data_pend <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: if (accept) begin
                    st  <= SQ_SEND;
                    cur <= wr;
                end
                SQ_SEND: st <= SQ_WAIT;
                SQ_WAIT: if (ser_done) st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
            if (busy_ok_evt) begin
                busy_pend <= 1'b0;
                busy_arm  <= 1'b0;
            end
            if (cap_evt && cur.kind == RSP_SHORT_BUSY) busy_arm <= 1'b1;
            if (tmo_evt) begin
                busy_pend <= 1'b0;
                data_pend <= 1'b0;
            end
            if (xfer_done) data_pend <= 1'b0;
            if (accept && wr.kind == RSP_SHORT_BUSY) busy_pend <= 1'b1;
            if (accept && wr.with_data) data_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/sdcmd_rsp.sv
module sdcmd_rsp
    import sdcmd_pkg::*;
#(
    parameter int WORDS = RSP_WORDS,
    parameter int WBITS = WORD_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cap,
    input  cmd_t                         cur,
    input  logic [WORDS*WBITS+CRC_W-1:0] frame,
    input  logic                         crc_flag,
    output logic [WORDS*WBITS-1:0]       resp,
    output logic                         crc_err,
    output logic                         idx_err
);
    localparam int RESP_W = WORDS * WBITS;
    localparam int BODY_W = RESP_W - CRC_W;

    logic [RESP_W-1:0] shifted;
    logic [WBITS-1:0]  word_q [WORDS];
    logic              short_kind;

    // CRC byte dropped: every stored bit sits CRC_W below its frame position
    assign shifted    = {{CRC_W{1'b0}}, frame[CRC_W +: BODY_W]};
    assign short_kind = (cur.kind == RSP_SHORT) || (cur.kind == RSP_SHORT_BUSY);
    assign crc_err    = cap && cur.crc_chk && (cur.kind != RSP_NONE) && crc_flag;
    assign idx_err    = cap && cur.idx_chk && short_kind &&
                        (frame[FR_IDX_LSB +: IDX_W] != cur.idx);

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic load;
        assign load = cap && ((cur.kind == RSP_LONG) || (gi == 0 && short_kind));
        always_ff @(posedge clk) begin
            if (rst)       word_q[gi] <= '0;
            else if (load) word_q[gi] <= shifted[gi*WBITS +: WBITS];
        end
        assign resp[gi*WBITS +: WBITS] = word_q[gi];
    end
endmodule

// File: rtl/sdcmd_sts.sv
module sdcmd_sts #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    logic [N-1:0] clr_mask;
    assign clr_mask = clr_we ? clr : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_mask) | set;
    end
endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
    import sdcmd_pkg::*;
#(
    parameter int ARG_BITS = ARG_W,
    parameter int N_WORDS  = RSP_WORDS,
    parameter int WBITS    = WORD_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           arg_we,
    input  logic [ARG_BITS-1:0]            arg_wdata,
    input  logic                           cmd_we,
    input  logic [15:0]                    cmd_wdata,
    input  logic                           sts_w1c_we,
    input  logic [STS_W-1:0]               sts_w1c_data,
    input  logic [3:0]                     dat_in,
    input  logic                           xfer_done,
    output logic                           ser_start,
    output logic [IDX_W-1:0]               ser_index,
    output logic [ARG_BITS-1:0]            ser_arg,
    output logic                           ser_long,
    input  logic                           ser_done,
    input  logic                           ser_timeout,
    input  logic                           ser_crc_err,
    input  logic [N_WORDS*WBITS+CRC_W-1:0] ser_frame,
    output logic [31:0]                    present_state,
    output logic [STS_W-1:0]               status,
    output logic [N_WORDS*WBITS-1:0]       resp_q
);
    cmd_t                cur;
    logic                cmd_inh, dat_inh, cap_evt, tmo_evt, busy_ok_evt;
    logic                crc_err, idx_err;
    logic [STS_W-1:0]    sts_set;
    logic [ARG_BITS-1:0] arg_q;

    always_ff @(posedge clk) begin
        if (rst)         arg_q <= '0;
        else if (arg_we) arg_q <= arg_wdata;
    end

    sdcmd_seq i_seq (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .ser_done(ser_done), .ser_timeout(ser_timeout), .dat0(dat_in[0]),
        .xfer_done(xfer_done), .ser_start(ser_start), .cur(cur),
        .cmd_inh(cmd_inh), .dat_inh(dat_inh), .cap_evt(cap_evt),
        .tmo_evt(tmo_evt), .busy_ok_evt(busy_ok_evt)
    );

    sdcmd_rsp #(.WORDS(N_WORDS), .WBITS(WBITS)) i_rsp (
        .clk(clk), .rst(rst), .cap(cap_evt), .cur(cur), .frame(ser_frame),
        .crc_flag(ser_crc_err), .resp(resp_q), .crc_err(crc_err), .idx_err(idx_err)
    );

    always_comb begin
        sts_set          = '0;
        sts_set[ST_CMPL] = (cap_evt && cur.kind != RSP_SHORT_BUSY) || busy_ok_evt;
        sts_set[ST_TMO]  = tmo_evt;
        sts_set[ST_CRC]  = crc_err;
        sts_set[ST_IDX]  = idx_err;
        sts_set[ST_ERR]  = tmo_evt | crc_err | idx_err;
    end

    sdcmd_sts #(.N(STS_W)) i_sts (
        .clk(clk), .rst(rst), .set(sts_set), .clr_we(sts_w1c_we),
        .clr(sts_w1c_data), .q(status)
    );

    assign ser_index     = cur.idx;
    assign ser_long      = (cur.kind == RSP_LONG);
    assign ser_arg       = arg_q;
    assign present_state = {8'h00, dat_in, 18'h0, dat_inh, cmd_inh};
endmodule

// File: rtl/sdcmd_issue_chk.sv
module sdcmd_issue_chk (
    input logic         clk,
    input logic         rst,
    input logic         ser_start,
    input logic         cmd_we,
    input logic [31:0]  present_state,
    input logic [4:0]   status,
    input logic [127:0] resp_q
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ser_start |=> !ser_start); // R1
    AST_START_HOLDS_INH: assert property (@(posedge clk) disable iff (rst)
        ser_start |-> present_state[0]); // R2
    AST_REFUSE_WHILE_INH: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && present_state[0]) |=> !ser_start); // R3
    AST_RESP_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !present_state[0] |=> $stable(resp_q)); // R5
    AST_IDX_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        $rose(status[3]) |-> status[4]); // R7
    AST_CRC_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> status[4]); // R8
    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> !present_state[0]); // R9
endmodule

bind sdcmd_issue sdcmd_issue_chk i_chk (
    .clk(clk), .rst(rst), .ser_start(ser_start), .cmd_we(cmd_we),
    .present_state(present_state), .status(status), .resp_q(resp_q)
);

// File: tb/test_sdcmd_issue.sv
module test_sdcmd_issue;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         arg_we = 1'b0, cmd_we = 1'b0, sts_w1c_we = 1'b0, xfer_done = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic [15:0]  cmd_wdata = '0;
    logic [4:0]   sts_w1c_data = '0;
    logic [3:0]   dat_in = 4'hF;
    logic         ser_done = 1'b0, ser_timeout = 1'b0, ser_crc_err = 1'b0;
    logic [135:0] ser_frame = '0;
    logic         ser_start, ser_long;
    logic [5:0]   ser_index;
    logic [31:0]  ser_arg, present_state;
    logic [4:0]   status;
    logic [127:0] resp_q;

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    sdcmd_issue i_sdcmd_issue (
        .clk(clk), .rst(rst), .arg_we(arg_we), .arg_wdata(arg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .sts_w1c_we(sts_w1c_we),
        .sts_w1c_data(sts_w1c_data), .dat_in(dat_in), .xfer_done(xfer_done),
        .ser_start(ser_start), .ser_index(ser_index), .ser_arg(ser_arg),
        .ser_long(ser_long), .ser_done(ser_done), .ser_timeout(ser_timeout),
        .ser_crc_err(ser_crc_err), .ser_frame(ser_frame),
        .present_state(present_state), .status(status), .resp_q(resp_q)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int           m_phase;      // 0 idle, 1 start cycle, 2 awaiting reply
    bit           m_busy_pend, m_busy_arm, m_data_pend;
    bit [5:0]     m_idx;
    bit [1:0]     m_kind;
    bit           m_ic, m_cc;
    bit [31:0]    m_arg;
    bit [127:0]   m_resp;
    bit [4:0]     m_sts;

    always @(posedge clk) begin : model
        bit       acc;
        bit [4:0] s;
        if (ser_start) start_cnt++;
        if (rst) begin
            m_phase = 0; m_busy_pend = 0; m_busy_arm = 0; m_data_pend = 0;
            m_idx = 0; m_kind = 0; m_ic = 0; m_cc = 0; m_arg = 0; m_resp = 0; m_sts = 0;
        end else begin
            s = 0;
            acc = cmd_we && m_phase == 0 &&
                  !((m_busy_pend || m_data_pend) && (cmd_wdata[5] || cmd_wdata[1:0] == 2'b11));
            if (m_busy_arm && dat_in[0]) begin
                s[0] = 1; m_busy_pend = 0; m_busy_arm = 0;
            end
            if (m_phase == 2 && ser_done) begin
                m_phase = 0;
                if (ser_timeout) begin
                    s[1] = 1; s[4] = 1; m_busy_pend = 0; m_data_pend = 0;
                end else begin
                    if (m_kind == 2'b01) m_resp = {8'h00, ser_frame[127:8]};
                    else if (m_kind[1])  m_resp[31:0] = ser_frame[39:8];
                    if (m_cc && m_kind != 2'b00 && ser_crc_err) begin s[2] = 1; s[4] = 1; end
                    if (m_ic && m_kind[1] && ser_frame[45:40] != m_idx) begin s[3] = 1; s[4] = 1; end
                    if (m_kind == 2'b11) m_busy_arm = 1; else s[0] = 1;
                end
            end else if (m_phase == 1) m_phase = 2;
            if (xfer_done) m_data_pend = 0;
            if (acc) begin
                m_phase = 1;
                m_idx = cmd_wdata[13:8]; m_kind = cmd_wdata[1:0];
                m_ic = cmd_wdata[4]; m_cc = cmd_wdata[3];
                if (cmd_wdata[1:0] == 2'b11) m_busy_pend = 1;
                if (cmd_wdata[5]) m_data_pend = 1;
            end
            if (arg_we) m_arg = arg_wdata;
            if (sts_w1c_we) m_sts = m_sts & ~sts_w1c_data;
            m_sts = m_sts | s;
        end
    end

    always @(posedge clk) begin : compare
        #(CLK_P/4);
        if (!rst) begin
            check(ser_start == (m_phase == 1), "R1 ser_start", ser_start, m_phase == 1);
            if (ser_start && m_phase == 1) begin
                check(ser_index == m_idx, "R1 ser_index", ser_index, m_idx);
                check(ser_arg == m_arg, "R1 ser_arg", ser_arg, m_arg);
                check(ser_long == (m_kind == 2'b01), "R1 ser_long", ser_long, m_kind == 2'b01);
            end
            check(present_state[0] == (m_phase != 0), "R2 cmd inhibit", present_state[0], m_phase != 0);
            check(present_state[1] == (m_busy_pend || m_data_pend), "R2 dat inhibit",
                  present_state[1], m_busy_pend || m_data_pend);
            check(present_state == {8'h00, dat_in, 20'h0} + {30'h0, present_state[1:0]},
                  "R2 line mirror", present_state, {8'h00, dat_in, 18'h0, present_state[1:0]});
            check(status[0] == m_sts[0], "R4 complete bit", status, m_sts);
            check(status[1] == m_sts[1], "R9 timeout bit", status, m_sts);
            check(status[2] == m_sts[2], "R8 crc bit", status, m_sts);
            check(status[3] == m_sts[3], "R7 index bit", status, m_sts);
            check(status[4] == m_sts[4], "R12 summary bit", status, m_sts);
            check(resp_q[31:0] == m_resp[31:0], "R5 word0", resp_q, m_resp);
            check(resp_q[127:32] == m_resp[127:32], "R6 upper words", resp_q, m_resp);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [15:0] mk(input logic [5:0] idx, input bit dp, input bit ic,
                                       input bit cc, input logic [1:0] kind);
        return {2'b00, idx, 2'b00, dp, ic, cc, 1'b0, kind};
    endfunction

    function automatic logic [135:0] frame48(input logic [5:0] idx, input logic [31:0] body);
        return {88'h0, 2'b00, idx, body, 8'h01};
    endfunction

    task automatic issue(input logic [15:0] c, input logic [31:0] a);
        arg_we = 1; arg_wdata = a;
        @(negedge clk);
        arg_we = 0; cmd_we = 1; cmd_wdata = c;
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic respond(input logic [135:0] f, input bit tmo, input bit crc, input int lat);
        repeat (lat) @(negedge clk);
        ser_done = 1; ser_timeout = tmo; ser_crc_err = crc; ser_frame = f;
        @(negedge clk);
        ser_done = 0; ser_timeout = 0; ser_crc_err = 0;
    endtask

    task automatic w1c(input logic [4:0] m);
        sts_w1c_we = 1; sts_w1c_data = m;
        @(negedge clk);
        sts_w1c_we = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int sc;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(status == 0, "R13 status after reset", status, 0);
        check(resp_q == 0, "R13 response after reset", resp_q, 0);
        check(present_state == 32'h00F0_0000, "R13 present after reset", present_state, 32'h00F0_0000);

        // no response type
        issue(mk(6'd0, 0, 0, 0, 2'b00), 32'h0);
        respond(frame48(6'd9, 32'hDEAD_BEEF), 0, 1, 2);
        check(status == 5'b00001, "R4 no-response completes", status, 5'b00001);
        check(resp_q == 0, "R4 response untouched", resp_q, 0);
        w1c(5'h1F);

        // short reply, checks pass
        issue(mk(6'd17, 0, 1, 1, 2'b10), 32'h1234_0000);
        respond(frame48(6'd17, 32'hA5A5_1234), 0, 0, 1);
        check(resp_q[31:0] == 32'hA5A5_1234, "R5 short word0", resp_q, 32'hA5A5_1234);
        w1c(5'h1F);
        check(status == 0, "R12 full clear", status, 0);

        // index mismatch, check enabled
        issue(mk(6'd17, 0, 1, 0, 2'b10), 32'h1);
        respond(frame48(6'd18, 32'h0000_0777), 0, 0, 3);
        check(status == 5'b11001, "R7 index error", status, 5'b11001);
        w1c(5'b00001);
        check(status == 5'b11000, "R12 partial clear", status, 5'b11000);
        w1c(5'h1F);

        // index mismatch, check disabled
        issue(mk(6'd17, 0, 0, 0, 2'b10), 32'h2);
        respond(frame48(6'd18, 32'h0000_0888), 0, 0, 1);
        check(status == 5'b00001, "R7 mismatch ignored", status, 5'b00001);
        w1c(5'h1F);

        // crc error enabled / disabled
        issue(mk(6'd8, 0, 0, 1, 2'b10), 32'h3);
        respond(frame48(6'd8, 32'h0000_01AA), 0, 1, 1);
        check(status == 5'b10101, "R8 crc error", status, 5'b10101);
        w1c(5'h1F);
        issue(mk(6'd8, 0, 0, 0, 2'b10), 32'h4);
        respond(frame48(6'd8, 32'h0000_01AB), 0, 1, 1);
        check(status == 5'b00001, "R8 crc ignored", status, 5'b00001);
        w1c(5'h1F);

        // long reply
        issue(mk(6'd2, 0, 0, 1, 2'b01), 32'h5);
        respond({8'h3F, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210}, 0, 0, 4);
        check(resp_q == 128'h0001_2345_6789_ABCD_EFFE_DCBA_9876_5432, "R6 long shifted",
              resp_q, 128'h0001_2345_6789_ABCD_EFFE_DCBA_9876_5432);
        w1c(5'h1F);

        // timeout
        issue(mk(6'd5, 0, 0, 0, 2'b10), 32'h6);
        respond(frame48(6'd5, 32'hFFFF_FFFF), 1, 0, 2);
        check(status == 5'b10010, "R9 timeout status", status, 5'b10010);
        check(resp_q == 128'h0001_2345_6789_ABCD_EFFE_DCBA_9876_5432, "R9 response kept",
              resp_q, 128'h0001_2345_6789_ABCD_EFFE_DCBA_9876_5432);
        w1c(5'h1F);

        // CMD inhibit refusal
        sc = start_cnt;
        issue(mk(6'd3, 0, 0, 0, 2'b10), 32'h7);
        cmd_we = 1; cmd_wdata = mk(6'd4, 0, 0, 0, 2'b10);
        @(negedge clk);
        cmd_we = 0;
        respond(frame48(6'd3, 32'h0000_0003), 0, 0, 1);
        check(start_cnt == sc + 1, "R3 refused under cmd inhibit", start_cnt - sc, 1);
        w1c(5'h1F);

        // busy wait
        dat_in = 4'hE;
        issue(mk(6'd7, 0, 0, 0, 2'b11), 32'h8);
        respond(frame48(6'd7, 32'h0000_0900), 0, 0, 1);
        check(status[0] == 0, "R10 no complete while busy", status, 0);
        check(present_state[1:0] == 2'b10, "R10 dat held, cmd free", present_state[1:0], 2'b10);
        sc = start_cnt;
        issue(mk(6'd12, 0, 0, 0, 2'b11), 32'h9);
        @(negedge clk);
        check(start_cnt == sc, "R3 refused under dat inhibit", start_cnt - sc, 0);
        issue(mk(6'd13, 0, 0, 0, 2'b10), 32'hA);
        respond(frame48(6'd13, 32'h0000_0D0D), 0, 0, 1);
        check(start_cnt == sc + 1, "R3 non-dat command accepted", start_cnt - sc, 1);
        w1c(5'h1F);
        repeat (2) @(negedge clk);
        check(status[0] == 0, "R10 still waiting", status, 0);
        dat_in = 4'hF;
        @(negedge clk);
        check(status[0] == 1, "R10 complete on dat0 high", status, 1);
        check(present_state[1] == 0, "R10 dat inhibit released", present_state[1], 0);
        w1c(5'h1F);

        // data present
        issue(mk(6'd18, 1, 0, 0, 2'b10), 32'hB);
        respond(frame48(6'd18, 32'h0000_0B00), 0, 0, 1);
        check(present_state[1] == 1, "R11 dat inhibit held", present_state[1], 1);
        sc = start_cnt;
        issue(mk(6'd24, 1, 0, 0, 2'b10), 32'hC);
        @(negedge clk);
        check(start_cnt == sc, "R3 data command refused", start_cnt - sc, 0);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
        check(present_state[1] == 0, "R11 released by xfer_done", present_state[1], 0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule